// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block picks which of four DMA channels is served next. Each channel can ask for service in two ways. One is a hardware request line, which counts only while the channel's mask bit is clear. The other is a software request bit held inside the block, which counts whatever the mask holds. Among the channels that are asking, the arbiter issues a one-hot grant. It holds that grant until the transfer logic returns a service-done pulse.

Two priority schemes are available. In fixed priority, channel 0 always wins over higher-numbered channels. In rotating priority, the channel just served drops to the bottom of the order when its service ends. A global disable stops any new grant from being issued. A master clear returns the arbiter to its idle state.

The block also supplies the four request bits of the controller's status byte. The mask register and the command bits come from the programming path as plain levels.

Top module: `dma_req_arbiter`

## Requirements
- R1: Reset or a `masterClr` pulse drops any grant (`grant`=0, `grantValid`=0), clears all software request bits, and restores the fixed order. After that, the next rotating-mode decision ranks channel 0 highest.
- R2: A hardware request `dreqIn[i]` can win a grant only while `maskIn[i]` is 0. With its mask bit at 1, the line alone never produces a grant.
- R3: A write with `reqWrEn`=1 changes one software request bit. `reqWrCode[1:0]` selects the channel, and `reqWrCode[2]`=1 sets the bit while 0 clears it. A set bit is granted even when the channel's mask bit is 1.
- R4: When `svcDone` and `svcTc` are both 1 while a channel is granted, that channel's software request bit clears. A `svcDone` without `svcTc` leaves the bit set, so the channel is granted again.
- R5: While `cmdDisable` is 1 and no grant is held, no new grant is issued.
- R6: With `cmdRotate`=0, the lowest-numbered requesting channel wins.
- R7: With `cmdRotate`=1, the channel named by `svcDone` becomes the lowest priority. The search for the next grant starts at the channel above it, wrapping from 3 to 0.
- R8: `grant` is one-hot or zero, and `grantValid` is 1 exactly when a grant is held. Once issued, a grant stays unchanged until `svcDone`, even if a higher-priority request arrives.
- R9: While idle, a grant appears on the first clock edge at which an eligible request is present. It drops on the edge that samples `svcDone`. The next grant can come on the following edge at the earliest.
- R10: `statusReq[i]` is `dreqIn[i]` OR software request bit i, independent of the mask. Bit i maps to status byte bit 4+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| masterClr | input | 1 | Synchronous master clear pulse |
| cmdDisable | input | 1 | Command disable bit (command bit 2); 1 blocks new grants |
| cmdRotate | input | 1 | Command priority bit (command bit 4); 1 selects rotating priority |
| maskIn | input | 4 | Mask register; bit i = 1 ignores `dreqIn[i]` |
| dreqIn | input | 4 | Hardware request lines |
| reqWrEn | input | 1 | Software request write strobe |
| reqWrCode | input | 3 | [1:0] channel, [2] set (1) or clear (0) |
| svcDone | input | 1 | Pulse from transfer logic ending the current service |
| svcTc | input | 1 | Terminal count qualifier, sampled with `svcDone` |
| grant | output | 4 | One-hot granted channel |
| grantValid | output | 1 | A grant is held |
| statusReq | output | 4 | Pending-request nibble for status bits [7:4] |

## Verification
The hardest state to reach from the ports is a rotation pointer that has moved away from its reset value. Reaching it takes a run of completed services in rotating mode, each ended by its own `svcDone`. A master clear must then be shown to restore channel 0 as the top priority. The bench holds all four requests high in rotating mode and serves five grants in turn, which walks the pointer round and back to channel 0. It then sets a software request, master-clears while that grant is held, and checks that the next decision with all four lines up goes to channel 0 and not channel 1.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arbState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadGrant;
    logic releaseGrant;
    logic rotate;
    logic clearSw;
  } arbStrobes_t;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        masterClr,
  input  logic        cmdDisable,
  input  logic        cmdRotate,
  input  logic        anyReq,
  input  logic        svcDone,
  input  logic        svcTc,
  output arbStrobes_t strb
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (masterClr) begin
      stateNext = ARB_IDLE;
    end else begin
      unique case (state)
        ARB_IDLE: begin
          if (!cmdDisable && anyReq) begin
            strb.loadGrant = 1'b1;
            stateNext      = ARB_BUSY;
          end
        end
        ARB_BUSY: begin
          if (svcDone) begin
            strb.releaseGrant = 1'b1;
            strb.rotate       = cmdRotate;
            strb.clearSw      = svcTc;
            stateNext         = ARB_IDLE;
          end
        end
        default: stateNext = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ARB_IDLE;
    else        state <= stateNext;
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_BUSY && !svcDone && !masterClr) |=> (state == ARB_BUSY));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadGrant, strb.releaseGrant}));

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterClr,
  input  logic              rotMode,
  input  logic [NUM_CH-1:0] maskIn,
  input  logic [NUM_CH-1:0] dreqIn,
  input  logic              reqWrEn,
  input  logic [SEL_W:0]    reqWrCode,
  input  arbStrobes_t       strb,
  output logic              anyReq,
  output logic [NUM_CH-1:0] grant,
  output logic              grantValid,
  output logic [NUM_CH-1:0] statusReq
);

  localparam int SET_BIT = SEL_W;

  logic [NUM_CH-1:0] swReq;
  logic [NUM_CH-1:0] effReq;
  logic [SEL_W-1:0]  lowPtr;
  logic [SEL_W-1:0]  winIdx;
  logic [SEL_W-1:0]  grantIdx;
  int                startIdx;

  assign effReq     = (dreqIn & ~maskIn) | swReq;
  assign anyReq     = |effReq;
  assign grantValid = |grant;
  assign statusReq  = dreqIn | swReq;

  // software request bits, one per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_swReq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        swReq[i] <= 1'b0;
      else if (masterClr)
        swReq[i] <= 1'b0;
      else if (reqWrEn && (reqWrCode[SEL_W-1:0] == SEL_W'(i)))
        swReq[i] <= reqWrCode[SET_BIT];
      else if (strb.clearSw && grant[i])
        swReq[i] <= 1'b0;
    end
  end

  // circular search starting just above the lowest-priority channel
  always_comb begin
    logic found;
    found    = 1'b0;
    winIdx   = '0;
    startIdx = rotMode ? ((int'(lowPtr) + 1) % NUM_CH) : 0;
    for (int k = 0; k < NUM_CH; k++) begin
      int idx;
      idx = (startIdx + k) % NUM_CH;
      if (!found && effReq[idx]) begin
        found  = 1'b1;
        winIdx = SEL_W'(idx);
      end
    end
  end

  always_comb begin
    grantIdx = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (grant[k]) grantIdx = SEL_W'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= '0;
      lowPtr <= SEL_W'(NUM_CH - 1);
    end else if (masterClr) begin
      grant  <= '0;
      lowPtr <= SEL_W'(NUM_CH - 1);
    end else begin
      if (strb.loadGrant)
        grant <= NUM_CH'(1) << winIdx;
      else if (strb.releaseGrant)
        grant <= '0;
      if (strb.rotate)
        lowPtr <= grantIdx;
    end
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !strb.releaseGrant && !masterClr) |=> $stable(grant));

  // R2
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grantValid) |-> ((grant & $past(effReq)) != '0));

  // R4
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearSw && !reqWrEn && !masterClr) |=> ((swReq & $past(grant)) == '0));

  // R1
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masterClr |=> (!grantValid && swReq == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterClr,
  input  logic              cmdDisable,
  input  logic              cmdRotate,
  input  logic [NUM_CH-1:0] maskIn,
  input  logic [NUM_CH-1:0] dreqIn,
  input  logic              reqWrEn,
  input  logic [SEL_W:0]    reqWrCode,
  input  logic              svcDone,
  input  logic              svcTc,
  output logic [NUM_CH-1:0] grant,
  output logic              grantValid,
  output logic [NUM_CH-1:0] statusReq
);

  arbStrobes_t strb;
  logic        anyReq;

  dma_arb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .masterClr  (masterClr),
    .cmdDisable (cmdDisable),
    .cmdRotate  (cmdRotate),
    .anyReq     (anyReq),
    .svcDone    (svcDone),
    .svcTc      (svcTc),
    .strb       (strb)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .masterClr  (masterClr),
    .rotMode    (cmdRotate),
    .maskIn     (maskIn),
    .dreqIn     (dreqIn),
    .reqWrEn    (reqWrEn),
    .reqWrCode  (reqWrCode),
    .strb       (strb),
    .anyReq     (anyReq),
    .grant      (grant),
    .grantValid (grantValid),
    .statusReq  (statusReq)
  );

  // R5
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grantValid && cmdDisable && !masterClr) |=> !grantValid);

endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       masterClr = 1'b0;
  logic       cmdDisable = 1'b0;
  logic       cmdRotate = 1'b0;
  logic [3:0] maskIn = 4'hF;
  logic [3:0] dreqIn = 4'h0;
  logic       reqWrEn = 1'b0;
  logic [2:0] reqWrCode = 3'd0;
  logic       svcDone = 1'b0;
  logic       svcTc = 1'b0;
  logic [3:0] grant;
  logic       grantValid;
  logic [3:0] statusReq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .masterClr(masterClr),
    .cmdDisable(cmdDisable), .cmdRotate(cmdRotate),
    .maskIn(maskIn), .dreqIn(dreqIn),
    .reqWrEn(reqWrEn), .reqWrCode(reqWrCode),
    .svcDone(svcDone), .svcTc(svcTc),
    .grant(grant), .grantValid(grantValid), .statusReq(statusReq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic doneSvc(input logic tc);
    svcDone = 1'b1;
    svcTc   = tc;
    step();
    svcDone = 1'b0;
    svcTc   = 1'b0;
  endtask

  task automatic swWrite(input logic [2:0] code);
    reqWrEn   = 1'b1;
    reqWrCode = code;
    step();
    reqWrEn   = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 grant", grant, 4'b0000);
    chk("R1 valid", {3'b0, grantValid}, 4'b0000);
    chk("R1 status", statusReq, 4'b0000);
  endtask

  task automatic t_mask();
    maskIn = 4'hF; dreqIn = 4'b0001;
    step(); step();
    chk("R2 masked", grant, 4'b0000);
    chk("R10 unmasked view", statusReq, 4'b0001);
    maskIn = 4'hE;
    step();
    chk("R2 unmasked grant", grant, 4'b0001);
    chk("R9 valid", {3'b0, grantValid}, 4'b0001);
    dreqIn = 4'b0000;
    doneSvc(1'b0);
    chk("R9 release", grant, 4'b0000);
    step();
    chk("R9 stays idle", grant, 4'b0000);
  endtask

  task automatic t_fixed();
    maskIn = 4'h0; dreqIn = 4'b1010;
    step();
    chk("R6 lowest of 1010", grant, 4'b0010);
    dreqIn = 4'b1011;
    step(); step();
    chk("R8 hold vs ch0", grant, 4'b0010);
    doneSvc(1'b0);
    chk("R9 drop", grant, 4'b0000);
    step();
    chk("R6 ch0 wins", grant, 4'b0001);
    dreqIn = 4'b1010;
    doneSvc(1'b0);
    step();
    chk("R6 ch1 wins", grant, 4'b0010);
    dreqIn = 4'b1000;
    doneSvc(1'b0);
    step();
    chk("R6 ch3 alone", grant, 4'b1000);
    dreqIn = 4'b0000;
    doneSvc(1'b0);
  endtask

  task automatic t_soft();
    maskIn = 4'hF; dreqIn = 4'b0000;
    swWrite(3'b110);
    chk("R10 sw status", statusReq, 4'b0100);
    step();
    chk("R3 sw bypasses mask", grant, 4'b0100);
    doneSvc(1'b0);
    chk("R4 release", grant, 4'b0000);
    step();
    chk("R4 no tc regrant", grant, 4'b0100);
    doneSvc(1'b1);
    step();
    chk("R4 tc cleared grant", grant, 4'b0000);
    chk("R4 tc cleared status", statusReq, 4'b0000);
  endtask

  task automatic t_disable();
    cmdDisable = 1'b1; maskIn = 4'h0; dreqIn = 4'b0001;
    step(); step(); step();
    chk("R5 disabled", grant, 4'b0000);
    cmdDisable = 1'b0;
    step();
    chk("R5 enabled", grant, 4'b0001);
    dreqIn = 4'b0000;
    doneSvc(1'b0);
    cmdDisable = 1'b1; maskIn = 4'hF;
    swWrite(3'b111);
    step();
    chk("R5 disabled sw", grant, 4'b0000);
    chk("R10 sw ch3", statusReq, 4'b1000);
    swWrite(3'b011);
    chk("R3 clear ch3", statusReq, 4'b0000);
    cmdDisable = 1'b0;
    step(); step();
    chk("R3 cleared no grant", grant, 4'b0000);
  endtask

  task automatic t_rotate();
    cmdRotate = 1'b1; maskIn = 4'h0; dreqIn = 4'b1111;
    step();
    chk("R7 first ch0", grant, 4'b0001);
    doneSvc(1'b0); step();
    chk("R7 then ch1", grant, 4'b0010);
    doneSvc(1'b0); step();
    chk("R7 then ch2", grant, 4'b0100);
    doneSvc(1'b0); step();
    chk("R7 then ch3", grant, 4'b1000);
    doneSvc(1'b0); step();
    chk("R7 wrap ch0", grant, 4'b0001);
    dreqIn = 4'b0000;
    doneSvc(1'b0);
  endtask

  task automatic t_mclr();
    maskIn = 4'hF; dreqIn = 4'b0000;
    swWrite(3'b110);
    step();
    chk("R1 pre grant", grant, 4'b0100);
    masterClr = 1'b1;
    step();
    masterClr = 1'b0;
    chk("R1 mclr grant", grant, 4'b0000);
    chk("R1 mclr status", statusReq, 4'b0000);
    maskIn = 4'h0; dreqIn = 4'b1111;
    step();
    chk("R1 order restored", grant, 4'b0001);
    dreqIn = 4'b0000;
    doneSvc(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mask();
    t_fixed();
    t_soft();
    t_disable();
    t_rotate();
    t_mclr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule